// File: doc/BRIEF.md
# Dual-Rail Null-Convention Half Adder with Fault Flag

This block adds two one-bit operands carried as dual-rail codes and produces a dual-rail sum and a dual-rail carry. Each operand and each result uses two wires. When both wires are low the value is the spacer, NULL. When exactly one wire is high the value is DATA: the high wire is rail 1 for TRUE or rail 0 for FALSE. A producer presents a DATA wavefront, waits for both results to become DATA, and then returns every input to NULL. When the results go back to NULL, the adder is ready for the next operand pair.

Each output rail comes from a threshold gate with hysteresis. The gate's held state is kept in a register and updated once per emulation clock. A gate sets when its input combination completes. Once set, it holds until every input rail of the adder is NULL. A fault gate watches the four output rails. It raises a flag when three or more of them are high, which no legal operand pair can cause. The flag is held until the inputs return to NULL.

Top module: `ncl_half_adder`

## Requirements
- R1: While rst_n is low, s0, s1, c0, c1 and fault are 0, and they stay 0 in the cycles before the released reset has been synchronised.
- R2: Rails are packed as {a1,a0} and {b1,b0}: 00 is NULL, 01 is FALSE and 10 is TRUE. Starting from NULL, a legal DATA pair on both operands gives, on the next rising clock edge, exactly one high rail per result. For the sum, s1 is high if A differs from B and s0 is high otherwise. For the carry, c1 is high if both are TRUE and c0 is high otherwise.
- R3: c1 rises only on an edge where a1 and b1 were both high.
- R4: An output rail is never set while either operand is NULL. For example, a1 alone, b0 alone, or a1 and a0 together with B NULL all leave every output at 0.
- R5: Once set, an output rail stays high as long as any input rail is high. This holds even when one operand has returned to NULL or the other operand has changed.
- R6: On the first rising edge where all four input rails were low, every output rail returns to 0.
- R7: fault rises one edge after three or more of the four output rails are high. This happens when a pair carries both rails high, or when operands change from one DATA value to another without passing through NULL.
- R8: Once high, fault stays high while any input rail is high, and it clears on the first edge where all input rails were low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulation clock; gate states update on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| a0 | input | 1 | Operand A, FALSE rail |
| a1 | input | 1 | Operand A, TRUE rail |
| b0 | input | 1 | Operand B, FALSE rail |
| b1 | input | 1 | Operand B, TRUE rail |
| s0 | output | 1 | Sum, FALSE rail |
| s1 | output | 1 | Sum, TRUE rail |
| c0 | output | 1 | Carry, FALSE rail |
| c1 | output | 1 | Carry, TRUE rail |
| fault | output | 1 | High when three or more output rails are DATA |

## Verification
The assertions check, on every cycle, the causes behind each change: a rising output rail needs two non-NULL operands on the edge before, a rising c1 needs a1 and b1, a falling rail or falling fault needs an all-NULL input edge, and a rising fault needs at least three high output rails. The bench scenarios show the rest: the full truth table of results, that a held result survives when one operand goes NULL, the path into fault when an operand changes without a spacer, and that the result is correct after a reset in the middle of an operation.

// File: rtl/ncl_ha_pkg.sv
package ncl_ha_pkg;
  localparam int unsigned OUT_RAILS = 4;
  localparam int unsigned IDX_C0    = 0;
  localparam int unsigned IDX_C1    = 1;
  localparam int unsigned IDX_S0    = 2;
  localparam int unsigned IDX_S1    = 3;

  typedef struct packed {
    logic t;
    logic f;
  } dual_rail_t;

  function automatic logic dr_is_null(input dual_rail_t v);
    return !(v.t || v.f);
  endfunction
endpackage

// File: rtl/ncl_rst_sync.sv
module ncl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ncl_hold_gate.sv
module ncl_hold_gate #(
  parameter bit CLEAR_WINS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic d;
  logic upd;

  always_comb begin
    d = q_o;
    if (CLEAR_WINS) begin
      if (clr_i)      d = 1'b0;
      else if (set_i) d = 1'b1;
    end else begin
      if (set_i)      d = 1'b1;
      else if (clr_i) d = 1'b0;
    end
    upd = (d != q_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_o <= 1'b0;
    else if (upd) q_o <= d;
  end
endmodule

// File: rtl/ncl_ha_terms.sv
module ncl_ha_terms
  import ncl_ha_pkg::*;
(
  input  dual_rail_t                a_i,
  input  dual_rail_t                b_i,
  output logic [OUT_RAILS-1:0]      set_o,
  output logic                      all_null_o
);
  always_comb begin
    set_o         = '0;
    set_o[IDX_C1] = a_i.t & b_i.t;
    set_o[IDX_C0] = (a_i.f & b_i.f) | (a_i.f & b_i.t) | (a_i.t & b_i.f);
    set_o[IDX_S1] = (a_i.f & b_i.t) | (a_i.t & b_i.f);
    set_o[IDX_S0] = (a_i.f & b_i.f) | (a_i.t & b_i.t);
    all_null_o    = dr_is_null(a_i) & dr_is_null(b_i);
  end
endmodule

// File: rtl/ncl_fault_det.sv
module ncl_fault_det
  import ncl_ha_pkg::*;
#(
  parameter int unsigned FAULT_MIN = 3
) (
  input  logic [OUT_RAILS-1:0] rails_i,
  output logic                 over_o
);
  localparam int unsigned CW = $clog2(OUT_RAILS + 1);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < OUT_RAILS; i++) cnt = cnt + CW'(rails_i[i]);
    over_o = (cnt >= CW'(FAULT_MIN));
  end
endmodule

// File: rtl/ncl_half_adder.sv
module ncl_half_adder
  import ncl_ha_pkg::*;
#(
  parameter int unsigned FAULT_MIN   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a0,
  input  logic a1,
  input  logic b0,
  input  logic b1,
  output logic s0,
  output logic s1,
  output logic c0,
  output logic c1,
  output logic fault
);
  logic                 rst_n_q;
  dual_rail_t           op_a;
  dual_rail_t           op_b;
  logic [OUT_RAILS-1:0] set_v;
  logic [OUT_RAILS-1:0] rail_q;
  logic                 in_null;
  logic                 too_many;

  assign op_a = '{t: a1, f: a0};
  assign op_b = '{t: b1, f: b0};

  ncl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_q)
  );

  ncl_ha_terms u_terms (
    .a_i        (op_a),
    .b_i        (op_b),
    .set_o      (set_v),
    .all_null_o (in_null)
  );

  for (genvar g = 0; g < OUT_RAILS; g++) begin : g_rail
    ncl_hold_gate #(.CLEAR_WINS(1'b0)) u_gate (
      .clk   (clk),
      .rst_n (rst_n_q),
      .set_i (set_v[g]),
      .clr_i (in_null),
      .q_o   (rail_q[g])
    );
  end

  ncl_fault_det #(.FAULT_MIN(FAULT_MIN)) u_fdet (
    .rails_i (rail_q),
    .over_o  (too_many)
  );

  ncl_hold_gate #(.CLEAR_WINS(1'b1)) u_fault (
    .clk   (clk),
    .rst_n (rst_n_q),
    .set_i (too_many),
    .clr_i (in_null),
    .q_o   (fault)
  );

  assign c0 = rail_q[IDX_C0];
  assign c1 = rail_q[IDX_C1];
  assign s0 = rail_q[IDX_S0];
  assign s1 = rail_q[IDX_S1];
endmodule

// File: rtl/ncl_half_adder_chk.sv
module ncl_half_adder_chk #(
  parameter int unsigned FAULT_MIN = 3
) (
  input logic clk,
  input logic rst_n_q,
  input logic a0,
  input logic a1,
  input logic b0,
  input logic b1,
  input logic s0,
  input logic s1,
  input logic c0,
  input logic c1,
  input logic fault
);
  logic [3:0] outs;
  logic       a_live;
  logic       b_live;
  logic       none_in;
  assign outs    = {s1, s0, c1, c0};
  assign a_live  = a0 | a1;
  assign b_live  = b0 | b1;
  assign none_in = !(a0 | a1 | b0 | b1);

  a_r3_carry_true_cause: assert property (@(posedge clk) disable iff (!rst_n_q)
    $rose(c1) |-> $past(a1 && b1));

  a_r4_set_needs_operands: assert property (@(posedge clk) disable iff (!rst_n_q)
    ($rose(s0) || $rose(s1) || $rose(c0) || $rose(c1)) |-> $past(a_live && b_live));

  a_r6_release_needs_null: assert property (@(posedge clk) disable iff (!rst_n_q)
    ($fell(s0) || $fell(s1) || $fell(c0) || $fell(c1)) |-> $past(none_in));

  a_r7_fault_cause: assert property (@(posedge clk) disable iff (!rst_n_q)
    $rose(fault) |-> $past($countones(outs) >= FAULT_MIN));

  a_r8_fault_clear_cause: assert property (@(posedge clk) disable iff (!rst_n_q)
    $fell(fault) |-> $past(none_in));
endmodule

bind ncl_half_adder ncl_half_adder_chk #(.FAULT_MIN(FAULT_MIN)) u_chk (
  .clk     (clk),
  .rst_n_q (rst_n_q),
  .a0      (a0),
  .a1      (a1),
  .b0      (b0),
  .b1      (b1),
  .s0      (s0),
  .s1      (s1),
  .c0      (c0),
  .c1      (c1),
  .fault   (fault)
);

// File: tb/ncl_half_adder_tb_top.sv
module ncl_half_adder_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 9;
  localparam int  WATCHDOG_CYCLES = 5000;

  // vector: {a1,a0,b1,b0} , {s1,s0,c1,c0} , fault-after-one-more-edge
  localparam logic [8:0] VEC [NVEC] = '{
    {4'b0101, 4'b0101, 1'b0},   // F+F
    {4'b0110, 4'b1001, 1'b0},   // F+T
    {4'b1001, 4'b1001, 1'b0},   // T+F
    {4'b1010, 4'b0110, 1'b0},   // T+T
    {4'b1000, 4'b0000, 1'b0},   // a1 only
    {4'b0001, 4'b0000, 1'b0},   // b0 only
    {4'b1100, 4'b0000, 1'b0},   // A contradictory, B NULL
    {4'b1101, 4'b1101, 1'b1},   // A contradictory, B FALSE
    {4'b1111, 4'b1111, 1'b1}    // both contradictory
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a0 = 1'b0, a1 = 1'b0, b0 = 1'b0, b1 = 1'b0;
  logic s0, s1, c0, c1, fault;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ncl_half_adder dut_i (
    .clk(clk), .rst_n(rst_n),
    .a0(a0), .a1(a1), .b0(b0), .b1(b1),
    .s0(s0), .s1(s1), .c0(c0), .c1(c1), .fault(fault)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [3:0] v);
    {a1, a0, b1, b0} = v;
  endtask

  task automatic check(input string req, input logic [3:0] exp_o, input logic exp_f);
    n_chk++;
    if ({s1, s0, c1, c0, fault} !== {exp_o, exp_f}) begin
      n_bad++;
      $display("FAIL %s: got {s1,s0,c1,c0,fault}=%b expected %b", req,
               {s1, s0, c1, c0, fault}, {exp_o, exp_f});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got running expected finished");
    finish_run();
  end

  initial begin
    #1;
    drive(4'b1010);
    tick();
    check("R1 in reset", 4'b0000, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1 sync release", 4'b0000, 1'b0);
    drive(4'b0000);
    repeat (3) tick();
    check("R1 after release", 4'b0000, 1'b0);

    // table walk: R2 legal results, R3 carry, R4 partial, R7/R8 fault
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][8:5]);
      tick();
      check("R2/R3/R4 result", VEC[i][4:1], 1'b0);
      tick();
      check("R7 fault after rails", VEC[i][4:1], VEC[i][0]);
      drive(4'b0000);
      tick();
      check("R6/R8 back to NULL", 4'b0000, 1'b0);
    end

    // R5: hysteresis while one operand returns to NULL
    drive(4'b1010);
    tick();
    check("R3 T+T", 4'b0110, 1'b0);
    drive(4'b0010);
    tick();
    check("R5 hold with A NULL", 4'b0110, 1'b0);
    drive(4'b0001);
    tick();
    check("R5 hold with B changed, A NULL", 4'b0110, 1'b0);
    drive(4'b0000);
    tick();
    check("R6 release", 4'b0000, 1'b0);

    // R7: DATA to DATA without spacer
    drive(4'b1010);
    tick();
    drive(4'b0101);
    tick();
    check("R7 rails merge", 4'b0111, 1'b0);
    tick();
    check("R7 fault raised", 4'b0111, 1'b1);
    drive(4'b0100);
    tick();
    check("R8 fault held, partial NULL", 4'b0111, 1'b1);
    drive(4'b0000);
    tick();
    check("R8 fault cleared", 4'b0000, 1'b0);

    // R1: reset during an operation
    drive(4'b0110);
    tick();
    check("R2 F+T before reset", 4'b1001, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 4'b0000, 1'b0);
    tick();
    drive(4'b0000);
    rst_n = 1'b1;
    repeat (3) tick();
    drive(4'b1001);
    tick();
    check("R2 T+F after reset", 4'b1001, 1'b0);
    drive(4'b0000);
    tick();
    check("R6 final release", 4'b0000, 1'b0);

    finish_run();
  end
endmodule